// File: doc/BRIEF.md
# Shared Bitmap Block Pool Allocator

This block keeps a single on-chip pool of bitmap storage that many transport connections draw from, instead of giving every connection a fixed bitmap of its own. The pool is cut into equal one-byte blocks, so no external fragmentation can arise. A connection's bitmap is built as a singly linked chain of these blocks. Blocks not in use are held on a last-in first-out free stack. Total bitmap storage therefore follows the amount of out-of-order data in flight across all connections, not the number of connections.

A client takes a block with `alloc_req` and hands one back with `free_req`. Both complete in the cycle they are asked. The answer to an allocate (`alloc_ok`, `alloc_idx`, `alloc_fail`) is combinational in that same cycle, and the stack changes at the next edge. A single access port reads the next-pointer and the data byte of any block combinationally, and writes either of them at the clock edge.

Every pin is a plain control or status signal. Nothing flows as a stream, so there is no valid/ready handshake and no back-pressure. A request is either served in its cycle or refused through `alloc_fail`.

Top module: `bpool_alloc`

## Requirements
- R1: After reset the free stack holds every index, with entry i equal to i. Allocations with no frees return indices in descending order, from NUM_BLOCKS-1 down to 0.
- R2: Once every block is allocated, an allocate request with no free request in the same cycle gives `alloc_ok`=0 and `alloc_fail`=1. It leaves the stack unchanged.
- R3: A block that is freed alone is the index returned by the next allocate (last in, first out).
- R4: When allocate and free are requested in the same cycle, the allocate returns `free_idx` and the stack depth stays the same. This also holds when the stack is empty.
- R5: In the cycle after a block is allocated, its data byte reads 0 and its next-pointer reads the null code, which is all ones at NUM_BLOCKS index width plus one bit. An allocation takes priority over a write to the same block in the same cycle.
- R6: When `byte_we` is set, `byte_wdata` is stored into block `acc_idx`. `acc_byte` shows it from the next cycle.
- R7: When `nxt_we` is set, `nxt_wdata` is stored as the next-pointer of block `acc_idx`. `acc_next` shows it from the next cycle.
- R8: Reset clears every data byte to 0 and sets every next-pointer to the null code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Take one block from the pool |
| alloc_ok | output | 1 | Allocate served this cycle |
| alloc_idx | output | IDX_W | Index of the block handed out |
| alloc_fail | output | 1 | Allocate refused: pool exhausted |
| free_req | input | 1 | Return block `free_idx` to the pool |
| free_idx | input | IDX_W | Index being returned |
| acc_idx | input | IDX_W | Block addressed by the access port |
| acc_next | output | IDX_W+1 | Next-pointer of `acc_idx` |
| acc_byte | output | CELL_W | Data byte of `acc_idx` |
| nxt_we | input | 1 | Write the next-pointer of `acc_idx` |
| nxt_wdata | input | IDX_W+1 | Next-pointer value to write |
| byte_we | input | 1 | Write the data byte of `acc_idx` |
| byte_wdata | input | CELL_W | Data byte to write |

## Verification
The assertions rely on the caller never freeing a block when the stack is already full. Such a push can only come from a double free, which the block does not check. The stimulus respects this by freeing only indices it has allocated earlier and not yet returned. The assertions also rely on the caller not writing a block in the same cycle it is allocated, unless that collision is itself under test. The bench keeps its own model of which indices are held, and it frees and writes only those.

// File: rtl/bpool_pkg.sv
package bpool_pkg;
  parameter int unsigned BP_BLOCKS = 128;
  parameter int unsigned BP_CELL_W = 8;
endpackage

// File: rtl/bpool_cell_array.sv
module bpool_cell_array #(
  parameter int unsigned N    = 128,
  parameter int unsigned IW   = 7,
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] cells [N];

  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n)                             cells[g] <= INIT;
      else if (clr_en && clr_idx == IW'(g))   cells[g] <= INIT;
      else if (wr_en && wr_idx == IW'(g))     cells[g] <= wr_data;
    end
  end

  assign rd_data = cells[rd_idx];

  // R5: a block being handed out comes back to its initial value
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> cells[$past(clr_idx)] == INIT);

  // R6 / R7: a plain write lands
  a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(clr_en && clr_idx == wr_idx)) |=> cells[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/bpool_free_stack.sv
module bpool_free_stack #(
  parameter int unsigned N  = 128,
  parameter int unsigned IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [IW-1:0] push_idx,
  output logic [IW-1:0] top_idx,
  output logic          empty,
  output logic          full
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [IW-1:0] stk [N];
  logic [CW-1:0] depth;

  assign empty   = (depth == '0);
  assign full    = (depth == CW'(N));
  assign top_idx = empty ? '0 : stk[IW'(depth - 1'b1)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= CW'(N);
    end else begin
      unique case ({push, pop})
        2'b10: if (!full) begin
          depth <= depth + 1'b1;
        end
        2'b01: if (!empty) depth <= depth - 1'b1;
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) stk[g] <= IW'(g);
      else if (push && !pop && !full && depth == CW'(g)) stk[g] <= push_idx;
    end
  end

  // R2: a pop on an empty stack leaves it empty
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
  // R3: a lone push deepens the stack by one
  a_r3_push_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> depth == $past(depth) + 1'b1);
  // R4: push and pop together keep the depth
  a_r4_bypass_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(depth));
  // R1: a lone pop on a non-empty stack shrinks it by one
  a_r1_pop_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> depth == $past(depth) - 1'b1);
endmodule

// File: rtl/bpool_alloc.sv
module bpool_alloc
  import bpool_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = BP_BLOCKS,
  parameter int unsigned CELL_W     = BP_CELL_W,
  localparam int unsigned IDX_W     = $clog2(NUM_BLOCKS),
  localparam int unsigned PTR_W     = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  output logic              alloc_ok,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              alloc_fail,
  input  logic              free_req,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic [IDX_W-1:0]  acc_idx,
  output logic [PTR_W-1:0]  acc_next,
  output logic [CELL_W-1:0] acc_byte,
  input  logic              nxt_we,
  input  logic [PTR_W-1:0]  nxt_wdata,
  input  logic              byte_we,
  input  logic [CELL_W-1:0] byte_wdata
);
  localparam logic [PTR_W-1:0]  NULL_PTR  = '1;
  localparam logic [CELL_W-1:0] ZERO_BYTE = '0;

  logic [IDX_W-1:0] stk_top;
  logic             stk_empty;
  logic             stk_full;

  bpool_free_stack #(.N(NUM_BLOCKS), .IW(IDX_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc_req),
    .push     (free_req),
    .push_idx (free_idx),
    .top_idx  (stk_top),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  assign alloc_ok   = alloc_req && (!stk_empty || free_req);
  assign alloc_fail = alloc_req && stk_empty && !free_req;
  assign alloc_idx  = free_req ? free_idx : stk_top;

  bpool_cell_array #(.N(NUM_BLOCKS), .IW(IDX_W), .W(PTR_W), .INIT(NULL_PTR)) u_next (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (alloc_ok),
    .clr_idx (alloc_idx),
    .wr_en   (nxt_we),
    .wr_idx  (acc_idx),
    .wr_data (nxt_wdata),
    .rd_idx  (acc_idx),
    .rd_data (acc_next)
  );

  bpool_cell_array #(.N(NUM_BLOCKS), .IW(IDX_W), .W(CELL_W), .INIT(ZERO_BYTE)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (alloc_ok),
    .clr_idx (alloc_idx),
    .wr_en   (byte_we),
    .wr_idx  (acc_idx),
    .wr_data (byte_wdata),
    .rd_idx  (acc_idx),
    .rd_data (acc_byte)
  );

  // R2: a request is either served or refused, never both
  a_r2_serve_or_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |-> (alloc_ok != alloc_fail));
  // R3: caller contract, no lone free into a full stack (double free)
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (free_req && !alloc_req) |-> !stk_full);
  // R4: a same-cycle free feeds the allocate directly
  a_r4_bypass_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && free_req) |-> (alloc_ok && alloc_idx == free_idx));
endmodule

// File: tb/bpool_alloc_test.sv
module bpool_alloc_test;
  localparam int IW = 7;
  localparam int PW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          alloc_req = 0, free_req = 0, nxt_we = 0, byte_we = 0;
  logic [IW-1:0] free_idx = '0, acc_idx = '0;
  logic [PW-1:0] nxt_wdata = '0;
  logic [7:0]    byte_wdata = '0;
  logic          alloc_ok, alloc_fail;
  logic [IW-1:0] alloc_idx;
  logic [PW-1:0] acc_next;
  logic [7:0]    acc_byte;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bpool_alloc uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_ok(alloc_ok),
    .alloc_idx(alloc_idx), .alloc_fail(alloc_fail), .free_req(free_req),
    .free_idx(free_idx), .acc_idx(acc_idx), .acc_next(acc_next),
    .acc_byte(acc_byte), .nxt_we(nxt_we), .nxt_wdata(nxt_wdata),
    .byte_we(byte_we), .byte_wdata(byte_wdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check combinational answer, take the edge
  task automatic op(input bit a, input bit f, input int fi,
                    input bit eok, input bit efail, input int eidx, input string tag);
    @(negedge clk);
    alloc_req = a; free_req = f; free_idx = IW'(fi);
    #5;
    if (a) begin
      chk({tag, " ok"}, alloc_ok, eok);
      chk({tag, " fail"}, alloc_fail, efail);
      if (eok) chk({tag, " idx"}, alloc_idx, eidx);
    end
    @(posedge clk); #1;
    alloc_req = 0; free_req = 0;
  endtask

  task automatic peek(input int idx, input int enx, input int eby, input string tag);
    @(negedge clk);
    acc_idx = IW'(idx);
    #5;
    chk({tag, " next"}, acc_next, enx);
    chk({tag, " byte"}, acc_byte, eby);
  endtask

  // fields: alloc, free, free_idx[7], exp_ok, exp_fail, exp_idx[7]
  localparam logic [17:0] VEC [6] = '{
    {1'b1, 1'b0, 7'd0,   1'b1, 1'b0, 7'd127},  // R1 first pop
    {1'b1, 1'b0, 7'd0,   1'b1, 1'b0, 7'd126},  // R1 descending
    {1'b0, 1'b1, 7'd127, 1'b0, 1'b0, 7'd0},    // R3 lone free
    {1'b1, 1'b0, 7'd0,   1'b1, 1'b0, 7'd127},  // R3 LIFO return
    {1'b1, 1'b1, 7'd126, 1'b1, 1'b0, 7'd126},  // R4 bypass
    {1'b1, 1'b0, 7'd0,   1'b1, 1'b0, 7'd125}   // R4 depth kept
  };

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R8: reset state of bytes and next pointers
    peek(0, 255, 0, "R8 blk0");
    peek(77, 255, 0, "R8 blk77");
    peek(127, 255, 0, "R8 blk127");

    for (int i = 0; i < 6; i++) begin
      op(VEC[i][17], VEC[i][16], int'(VEC[i][15:9]), VEC[i][8], VEC[i][7],
         int'(VEC[i][6:0]), $sformatf("R1-R4 vec%0d", i));
    end
    // held now: 127,126,125

    // R6: byte write / read
    @(negedge clk); acc_idx = 7'd125; byte_we = 1; byte_wdata = 8'hA5;
    @(posedge clk); #1 byte_we = 0;
    peek(125, 255, 8'hA5, "R6 byte");
    // R7: next-pointer write / read
    @(negedge clk); acc_idx = 7'd125; nxt_we = 1; nxt_wdata = 8'd127;
    @(posedge clk); #1 nxt_we = 0;
    peek(125, 127, 8'hA5, "R7 link");

    // R5: recycle 125, it comes back clean
    op(0, 1, 125, 0, 0, 0, "R5 free");
    op(1, 0, 0, 1, 0, 125, "R5 realloc");
    peek(125, 255, 0, "R5 fresh");

    // R5: allocation wins over same-cycle write to that block
    op(0, 1, 125, 0, 0, 0, "R5 free2");
    @(negedge clk); acc_idx = 7'd125; byte_we = 1; byte_wdata = 8'h3C;
    nxt_we = 1; nxt_wdata = 8'd4; alloc_req = 1;
    #5 chk("R5 collide idx", alloc_idx, 125);
    @(posedge clk); #1 byte_we = 0; nxt_we = 0; alloc_req = 0;
    peek(125, 255, 0, "R5 collide");

    // R1/R2: drain the rest, 124 down to 0
    for (int k = 124; k >= 0; k--) op(1, 0, 0, 1, 0, k, "R1 drain");
    op(1, 0, 0, 0, 1, 0, "R2 exhausted");
    op(1, 0, 0, 0, 1, 0, "R2 still exhausted");
    // R4: bypass works on an empty stack
    op(1, 1, 3, 1, 0, 3, "R4 empty bypass");
    op(1, 0, 0, 0, 1, 0, "R4 empty kept");
    // R3: lone free then alloc
    op(0, 1, 9, 0, 0, 0, "R3 free9");
    op(1, 0, 0, 1, 0, 9, "R3 get9");
    op(1, 0, 0, 0, 1, 0, "R2 empty again");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule